// File: doc/BRIEF.md
# Round-Trip Pointer-Bank Round-Robin Crossbar Scheduler

This block computes one crossbar matching per cell slot for an N-port switch whose request/grant exchange spans several slots. Input selectors see which virtual output queues hold cells and pick one output each. Output selectors pick one requesting input each. Because a result only comes back D slots after its request left, every input and every output keeps a bank of D round-robin pointers instead of one. The slot number modulo D chooses the bank entry. A pointer entry is rewritten only once the result of its own earlier use has come back, so it is never reused before that result is known.

The round trip is modelled inside the block by two register chains that shift on the slot strobe. The request path has floor(D/2) stages and the return path has the remaining stages, including the pointer update itself. Each request and each grant carries the ID of the pointer entry that produced it. One arbiter per input and one per output is shared by all D entries, and a multiplexer feeds it the entry for the current ID. With D=1 the block degenerates to an ordinary single-pointer round-robin scheduler.

Top module: `slot_rr_sched`

## Requirements
- R1: Every published grant matrix is one-to-one: bit i*N+o set means input i is granted output o, and each input row and each output column holds at most one set bit.
- R2: In a slot using entry k, input i requests the first output o, searching cyclically from its pointer R_i[k], for which voq bit i*N+o is set; it requests nothing if its row is empty.
- R3: An output answering a request tagged k grants the first requesting input, searching cyclically from G_o[k], and at that moment sets G_o[k] to (granted input + 1) mod N.
- R4: The n-th slot strobe after reset (counting from 0) issues requests with entry n mod D, and the grant published for it carries grantId = n mod D, so successive grants count up modulo D.
- R5: The grant for slot n is published on the clock edge of strobe n + floor(D/2); grantValid is low until then and then stays high.
- R6: R_i[k] becomes (granted output + 1) mod N only when the grant tagged k returns, before entry k is used again, and is left unchanged when input i was not granted; other entries are not touched.
- R7: Clock cycles without a slot strobe change no output and no pointer, and voq is ignored in them.
- R8: Reset clears all pointers to 0, the slot count to 0, grantValid to 0 and grantMat and grantId to 0.
- R9: With D=1 each strobe's grant is published on that same strobe's edge and every pointer updates once per slot, as in a single-pointer scheduler.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slotStrobe | input | 1 | One-cycle pulse marking a cell slot boundary |
| voq | input | N*N | Occupancy, bit i*N+o set when input i holds a cell for output o |
| grantMat | output | N*N | Published grant matrix, bit i*N+o grants input i to output o |
| grantId | output | max(1,clog2(D)) | Pointer-entry ID that produced the published grant |
| grantValid | output | 1 | High once a grant has been published since reset |

## Verification
The bench first drives a full occupancy matrix so that every entry starts on the same pointer: slots 0 to D-1 must each grant input 0 to output 0, and slot D must give a different pairing, which a design sharing one pointer across entries, or updating an entry from the wrong returning ID, would get wrong at once. Latency is checked at the first published slot, where an off-by-one pipeline shows up as an early or late grantValid. Cycles with a changing voq and no strobe must leave outputs frozen, and a D=1 instance runs the same stimulus, where any leftover delay would publish grants one slot late.

// File: rtl/slot_rr_pkg.sv
package slot_rr_pkg;
  // Strobes from control to datapath for one slot boundary.
  typedef struct packed {
    logic advance;   // shift pipelines, update returning pointers
    logic answerOn;  // a real request sits at the output selectors
  } slot_ctl_t;
endpackage

// File: rtl/slot_rr_pick.sv
module slot_rr_pick #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic          found,
  output logic [PW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[(int'(ptr) + k) % N]) begin
        found = 1'b1;
        idx   = PW'((int'(ptr) + k) % N);
      end
    end
  end
endmodule

// File: rtl/slot_rr_ctrl.sv
module slot_rr_ctrl
  import slot_rr_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int REQ_LAT = 2,
  parameter int IDW     = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           slotStrobe,
  output slot_ctl_t      ctl,
  output logic [IDW-1:0] issueId
);
  logic [IDW-1:0] slotQ;
  logic [3:0]     fillQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      slotQ <= '0;
      fillQ <= '0;
    end else if (slotStrobe) begin
      slotQ <= (slotQ == IDW'(DEPTH - 1)) ? '0 : slotQ + IDW'(1);
      if (fillQ != 4'(REQ_LAT)) fillQ <= fillQ + 4'd1;
    end
  end

  always_comb begin
    ctl.advance  = slotStrobe;
    ctl.answerOn = slotStrobe && (fillQ == 4'(REQ_LAT));
    issueId      = slotQ;
  end
endmodule

// File: rtl/slot_rr_dp.sv
module slot_rr_dp
  import slot_rr_pkg::*;
#(
  parameter int N        = 4,
  parameter int DEPTH    = 4,
  parameter int REQ_LAT  = 2,
  parameter int RET_REGS = 1,
  parameter int PW       = 2,
  parameter int IDW      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  slot_ctl_t        ctl,
  input  logic [IDW-1:0]   issueId,
  input  logic [N*N-1:0]   voq,
  output logic [N*N-1:0]   grantMat,
  output logic [IDW-1:0]   grantId,
  output logic             grantValid
);
  typedef struct packed {
    logic [IDW-1:0] id;
    logic [N*N-1:0] mat;
  } stage_t;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (int'(p) == N - 1) ? '0 : p + PW'(1);
  endfunction

  logic [PW-1:0] reqPtr   [N][DEPTH];
  logic [PW-1:0] grantPtr [N][DEPTH];

  stage_t issue, arrive, answer, back;
  logic [N-1:0]  iFound, oFound;
  logic [PW-1:0] iIdx [N];
  logic [PW-1:0] oIdx [N];
  logic [N-1:0]  colReq [N];
  logic [N-1:0]  backHit;
  logic [PW-1:0] backIdx [N];

  // Input selectors: one shared arbiter per input, pointer entry muxed by ID.
  for (genvar i = 0; i < N; i++) begin : g_in
    slot_rr_pick #(.N(N), .PW(PW)) u_ipick (
      .req(voq[i*N +: N]), .ptr(reqPtr[i][issueId]),
      .found(iFound[i]), .idx(iIdx[i]));
  end

  always_comb begin
    issue.id  = issueId;
    issue.mat = '0;
    for (int i = 0; i < N; i++)
      if (iFound[i]) issue.mat[i*N + int'(iIdx[i])] = 1'b1;
  end

  // Request path.
  if (REQ_LAT == 0) begin : g_req0
    assign arrive = issue;
  end else begin : g_reqN
    stage_t reqPipe [REQ_LAT];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < REQ_LAT; s++) reqPipe[s] <= '0;
      end else if (ctl.advance) begin
        reqPipe[0] <= issue;
        for (int s = 1; s < REQ_LAT; s++) reqPipe[s] <= reqPipe[s-1];
      end
    end
    assign arrive = reqPipe[REQ_LAT-1];
  end

  // Output selectors.
  for (genvar o = 0; o < N; o++) begin : g_out
    always_comb
      for (int i = 0; i < N; i++) colReq[o][i] = arrive.mat[i*N + o];
    slot_rr_pick #(.N(N), .PW(PW)) u_opick (
      .req(colReq[o]), .ptr(grantPtr[o][arrive.id]),
      .found(oFound[o]), .idx(oIdx[o]));
  end

  always_comb begin
    answer.id  = arrive.id;
    answer.mat = '0;
    for (int o = 0; o < N; o++)
      if (oFound[o]) answer.mat[int'(oIdx[o])*N + o] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int o = 0; o < N; o++)
        for (int k = 0; k < DEPTH; k++) grantPtr[o][k] <= '0;
    end else if (ctl.answerOn) begin
      for (int o = 0; o < N; o++)
        if (oFound[o]) grantPtr[o][arrive.id] <= bump(oIdx[o]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grantMat   <= '0;
      grantId    <= '0;
      grantValid <= 1'b0;
    end else if (ctl.answerOn) begin
      grantMat   <= answer.mat;
      grantId    <= answer.id;
      grantValid <= 1'b1;
    end
  end

  // Return path; the pointer write below is its last stage.
  if (RET_REGS == 0) begin : g_ret0
    assign back = answer;
  end else begin : g_retN
    stage_t retPipe [RET_REGS];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < RET_REGS; s++) retPipe[s] <= '0;
      end else if (ctl.advance) begin
        retPipe[0] <= answer;
        for (int s = 1; s < RET_REGS; s++) retPipe[s] <= retPipe[s-1];
      end
    end
    assign back = retPipe[RET_REGS-1];
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      backHit[i] = |back.mat[i*N +: N];
      backIdx[i] = '0;
      for (int o = 0; o < N; o++)
        if (back.mat[i*N + o]) backIdx[i] = PW'(o);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++)
        for (int k = 0; k < DEPTH; k++) reqPtr[i][k] <= '0;
    end else if (ctl.advance) begin
      for (int i = 0; i < N; i++)
        if (backHit[i]) reqPtr[i][back.id] <= bump(backIdx[i]);
    end
  end
endmodule

// File: rtl/slot_rr_sched.sv
module slot_rr_sched
  import slot_rr_pkg::*;
#(
  parameter int N     = 4,
  parameter int DEPTH = 4,
  localparam int PW       = (N > 1) ? $clog2(N) : 1,
  localparam int IDW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int REQ_LAT  = DEPTH / 2,
  localparam int RET_REGS = DEPTH - REQ_LAT - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slotStrobe,
  input  logic [N*N-1:0]   voq,
  output logic [N*N-1:0]   grantMat,
  output logic [IDW-1:0]   grantId,
  output logic             grantValid
);
  slot_ctl_t      ctl;
  logic [IDW-1:0] issueId;

  slot_rr_ctrl #(.DEPTH(DEPTH), .REQ_LAT(REQ_LAT), .IDW(IDW)) u_ctrl (
    .clk(clk), .rst(rst), .slotStrobe(slotStrobe),
    .ctl(ctl), .issueId(issueId));

  slot_rr_dp #(.N(N), .DEPTH(DEPTH), .REQ_LAT(REQ_LAT), .RET_REGS(RET_REGS),
               .PW(PW), .IDW(IDW)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .issueId(issueId), .voq(voq),
    .grantMat(grantMat), .grantId(grantId), .grantValid(grantValid));
endmodule

// File: rtl/slot_rr_sched_chk.sv
module slot_rr_sched_chk #(
  parameter int N     = 4,
  parameter int DEPTH = 4,
  parameter int IDW   = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           slotStrobe,
  input logic [N*N-1:0] grantMat,
  input logic [IDW-1:0] grantId,
  input logic           grantValid
);
  logic [N-1:0] colView [N];
  always_comb
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++) colView[o][i] = grantMat[i*N + o];

  for (genvar g = 0; g < N; g++) begin : g_one
    assert_row_onehot_R1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grantMat[g*N +: N]));
    assert_col_onehot_R1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(colView[g]));
  end

  assert_id_step_R4: assert property (@(posedge clk) disable iff (rst)
    (slotStrobe && grantValid) |=>
      (grantId == IDW'((int'($past(grantId)) + 1) % DEPTH)));

  assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    grantValid |=> grantValid);

  assert_hold_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !slotStrobe |=> ($stable(grantMat) && $stable(grantId) && $stable(grantValid)));
endmodule

bind slot_rr_sched slot_rr_sched_chk #(.N(N), .DEPTH(DEPTH), .IDW(IDW)) u_chk (
  .clk(clk), .rst(rst), .slotStrobe(slotStrobe),
  .grantMat(grantMat), .grantId(grantId), .grantValid(grantValid));

// File: tb/slot_rr_sched_tb.sv
module slot_rr_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int NV = 20;
  localparam logic [15:0] VEC [NV] = '{
    16'hFFFF, 16'h0000, 16'h8421, 16'h1111, 16'hF000, 16'h1248,
    16'hFFFF, 16'hFFFF, 16'h00F0, 16'h2222, 16'hA5A5, 16'h5A5A,
    16'h1111, 16'h1111, 16'h8888, 16'h0F0F, 16'hFFFF, 16'h0001,
    16'h3C3C, 16'hFFFF };

  logic clk = 0, rst = 1, slotStrobe = 0;
  logic [15:0] voq = '0;
  logic [15:0] gm0, gm1;
  logic [1:0]  gid0;
  logic        gid1;
  logic        gv0, gv1;
  int tests = 0, fails = 0, cyc = 0;

  int rpM [2][8][N];
  int gpM [2][8][N];
  int stepN [2];
  logic [15:0] expHist [2][512];

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_rr_sched #(.N(4), .DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .slotStrobe(slotStrobe), .voq(voq),
    .grantMat(gm0), .grantId(gid0), .grantValid(gv0));

  slot_rr_sched #(.N(4), .DEPTH(1)) u_dut_single (
    .clk(clk), .rst(rst), .slotStrobe(slotStrobe), .voq(voq),
    .grantMat(gm1), .grantId(gid1), .grantValid(gv1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int depthOf(input int d);
    return (d == 0) ? 4 : 1;
  endfunction

  task automatic modelClear();
    for (int d = 0; d < 2; d++) begin
      stepN[d] = 0;
      for (int k = 0; k < 8; k++)
        for (int p = 0; p < N; p++) begin rpM[d][k][p] = 0; gpM[d][k][p] = 0; end
    end
  endtask

  // Reference behaviour from R2/R3/R6: pointer entries are private per slot ID,
  // so applying an update at issue time is equivalent at the ports.
  task automatic modelStep(input int d, input logic [15:0] v);
    int k;
    logic [15:0] rq, ans;
    k = stepN[d] % depthOf(d);
    rq = '0; ans = '0;
    for (int i = 0; i < N; i++) begin
      bit hit = 0;
      for (int c = 0; c < N; c++) begin
        int j = (rpM[d][k][i] + c) % N;
        if (!hit && v[i*N+j]) begin hit = 1; rq[i*N+j] = 1'b1; end
      end
    end
    for (int o = 0; o < N; o++) begin
      bit hit = 0;
      for (int c = 0; c < N; c++) begin
        int ii = (gpM[d][k][o] + c) % N;
        if (!hit && rq[ii*N+o]) begin
          hit = 1; ans[ii*N+o] = 1'b1;
          gpM[d][k][o] = (ii + 1) % N;
          rpM[d][k][ii] = (o + 1) % N;
        end
      end
    end
    expHist[d][stepN[d]] = ans;
    stepN[d]++;
  endtask

  task automatic checkModel(input int d);
    int n, lat, dep;
    logic [15:0] m; int id; logic v;
    n = stepN[d] - 1;
    dep = depthOf(d);
    lat = dep / 2;
    m  = (d == 0) ? gm0 : gm1;
    id = (d == 0) ? int'(gid0) : int'(gid1);
    v  = (d == 0) ? gv0 : gv1;
    if (n >= lat) begin
      chk(v == 1'b1, "R5 grantValid", int'(v), 1);
      chk(m == expHist[d][n-lat], "R2/R3/R6 grantMat", int'(m), int'(expHist[d][n-lat]));
      chk(id == (n - lat) % dep, "R4 grantId", id, (n - lat) % dep);
    end else begin
      chk(v == 1'b0, "R5 grantValid early", int'(v), 0);
    end
    for (int g = 0; g < N; g++) begin
      logic [3:0] col;
      for (int i = 0; i < N; i++) col[i] = m[i*N+g];
      chk($countones(m[g*N +: N]) <= 1 && $countones(col) <= 1,
          "R1 one-to-one", int'(m), 0);
    end
  endtask

  task automatic slot(input logic [15:0] v);
    @(negedge clk);
    voq = v; slotStrobe = 1'b1;
    @(negedge clk);
    slotStrobe = 1'b0;
    modelStep(0, v); modelStep(1, v);
    checkModel(0); checkModel(1);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; slotStrobe = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    modelClear();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] hm; logic [1:0] hid; logic hv;
    doReset();
    @(negedge clk);
    // R8: reset state
    chk(gv0 == 0 && gm0 == 0 && gid0 == 0, "R8 reset outputs", int'(gm0), 0);
    chk(gv1 == 0 && gm1 == 0, "R8 reset outputs single", int'(gm1), 0);

    // Full occupancy: every fresh entry gives input0->output0.
    slot(16'hFFFF);
    chk(gm1 == 16'h0001 && gv1, "R9 single first slot", int'(gm1), 16'h0001);
    chk(!gv0, "R5 not yet published", int'(gv0), 0);
    slot(16'hFFFF);
    chk(gm1 == 16'h0012, "R9 single pointer advanced", int'(gm1), 16'h0012);
    for (int s = 2; s < 6; s++) begin
      slot(16'hFFFF);
      chk(gm0 == 16'h0001 && gid0 == 2'(s - 2), "R6 fresh entry untouched",
          int'(gm0), 16'h0001);
    end
    slot(16'hFFFF);
    chk(gm0 == 16'h0012 && gid0 == 2'd0, "R6 entry 0 reused after return",
        int'(gm0), 16'h0012);

    // Table of occupancy patterns against the reference.
    for (int t = 0; t < NV; t++) slot(VEC[t]);

    // R7: cycles without a strobe leave outputs alone.
    hm = gm0; hid = gid0; hv = gv0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      voq = 16'(c * 16'h3331);
    end
    chk(gm0 == hm && gid0 == hid && gv0 == hv, "R7 hold without strobe",
        int'(gm0), int'(hm));
    slot(16'h8421);
    slot(16'h1111);

    // R8: reset in mid-run.
    doReset();
    @(negedge clk);
    chk(gv0 == 0 && gm0 == 0 && gv1 == 0, "R8 mid-run reset", int'(gv0), 0);
    slot(16'h1111);
    chk(gm1 == 16'h0001, "R9 column contention after reset", int'(gm1), 16'h0001);
    for (int t = 0; t < NV; t++) slot(VEC[NV-1-t]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule